// File: doc/BRIEF.md
# Address/Opcode Filtered Event Counter

This block is a performance-monitoring counter. It watches a stream of incoming transaction requests. Each request carries a 40-bit physical address, a 4-bit packet header opcode and a 4-bit message class. The block counts the requests that pass a programmable filter. Software programs the filter through a small register port. A 64-bit match register holds a cache-line-granular address, an opcode, a message class and a match-select field. An 8-bit event-select register turns filtered counting on when it holds the match event code.

A request is captured on the clock edge where `txn_valid` is high. It is compared against the programmed values in the following cycle, and the counter steps on the next edge. The counter is 48 bits wide and wraps to zero. A sticky flag records each wrap. Software can clear the counter, preload it, and enable or pause counting.

Top module: `evt_filter_counter`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, and the event-select and match registers read 0.
- R2: Register port addresses are 0 for event select (bits 7:0), 1 for the match register, 2 for the counter (bits 47:0, writable) and 3 for status (bit 0 is the overflow flag, read-only). In the match register, bits 39:3 hold the address, bits 43:40 the opcode, bits 47:44 the message class and bits 63:62 the match select. Bits 61:48 and 2:0 read as zero and ignore writes. Unused high bits of the other registers read as zero.
- R3: Requests are counted only while the event-select register holds 0x35.
- R4: Match select 00 stops counting.
- R5: Match select 01 counts requests whose address bits 39:3 equal the programmed address. Address bits 2:0, the opcode and the class are ignored.
- R6: Match select 10 counts requests whose opcode and message class both equal the programmed values, whatever the address.
- R7: Match select 11 counts only requests that match on both the address and the opcode/class.
- R8: A matching request sampled at edge k is reflected in the count after edge k+1. Back-to-back requests are each evaluated, one per cycle.
- R9: Requests sampled while `cnt_en` is low are not counted.
- R10: `cnt_clr` zeroes the count and the overflow flag on the next edge. It wins over a same-cycle increment and a same-cycle counter write.
- R11: An increment from 0xFFFF_FFFF_FFFF wraps the count to 0 and sets the overflow flag. The flag stays set until `cnt_clr`, and a counter write does not clear it.
- R12: A counter write loads the written value on the next edge. It takes priority over a same-cycle increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data (combinational) |
| cnt_en | input | 1 | Counting enable, sampled with the request |
| cnt_clr | input | 1 | Synchronous counter and flag clear |
| txn_valid | input | 1 | Request valid strobe |
| txn_paddr | input | 40 | Request physical address |
| txn_opcode | input | 4 | Request packet header opcode |
| txn_class | input | 4 | Request message class |
| count_o | output | 48 | Current count |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
The bench changes address bits 2:0 on an otherwise matching request. A design that compared the full address would then miss the count. It flips bit 3 and bit 39 separately, so a comparator that dropped an address slice would count a request it should reject. In opcode mode, the bench changes the opcode and the class one at a time, which exposes a filter that tests only one of them. It also samples the count one cycle after a request, where the count must not have moved yet, to catch a design that is off by one stage. It places a clear in the same cycle as a pending hit, and it drives a preloaded all-ones counter through a wrap, to catch a design with the wrong priority or a flag that is not sticky.

// File: rtl/efc_pkg.sv
package efc_pkg;
   localparam int MR_W     = 64;
   localparam int ADDR_LO  = 3;
   localparam int ADDR_HI  = 39;
   localparam int MA_W     = ADDR_HI - ADDR_LO + 1;
   localparam int OPC_LO   = 40;
   localparam int CLS_LO   = 44;
   localparam int SEL_LO   = 62;
   localparam int FLD_W    = 4;

   typedef enum logic [1:0] {
      MS_OFF  = 2'b00,
      MS_ADDR = 2'b01,
      MS_OPC  = 2'b10,
      MS_BOTH = 2'b11
   } msel_e;

   localparam logic [1:0] RA_EVT   = 2'd0;
   localparam logic [1:0] RA_MATCH = 2'd1;
   localparam logic [1:0] RA_COUNT = 2'd2;
   localparam logic [1:0] RA_STAT  = 2'd3;

   typedef struct packed {
      msel_e              sel;
      logic [FLD_W-1:0]   cls;
      logic [FLD_W-1:0]   opc;
      logic [MA_W-1:0]    addr;
   } match_cfg_t;
endpackage

// File: rtl/efc_regs.sv
module efc_regs
   import efc_pkg::*;
#(
   parameter int EVT_W = 8,
   parameter int CNT_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [MR_W-1:0]   wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              ovf,
   output logic [EVT_W-1:0]  evt_sel,
   output match_cfg_t        mcfg,
   output logic              cnt_wr,
   output logic [MR_W-1:0]   rdata
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[SEL_LO-1:CLS_LO+FLD_W], wdata[ADDR_LO-1:0]};

   assign cnt_wr = we && (addr == RA_COUNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_sel <= '0;
         mcfg    <= '0;
      end else if (we) begin
         if (addr == RA_EVT)
            evt_sel <= wdata[EVT_W-1:0];
         if (addr == RA_MATCH) begin
            mcfg.sel  <= msel_e'(wdata[SEL_LO+1:SEL_LO]);
            mcfg.cls  <= wdata[CLS_LO+FLD_W-1:CLS_LO];
            mcfg.opc  <= wdata[OPC_LO+FLD_W-1:OPC_LO];
            mcfg.addr <= wdata[ADDR_HI:ADDR_LO];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_EVT:   rdata[EVT_W-1:0] = evt_sel;
         RA_MATCH: begin
            rdata[SEL_LO+1:SEL_LO]          = mcfg.sel;
            rdata[CLS_LO+FLD_W-1:CLS_LO]    = mcfg.cls;
            rdata[OPC_LO+FLD_W-1:OPC_LO]    = mcfg.opc;
            rdata[ADDR_HI:ADDR_LO]          = mcfg.addr;
         end
         RA_COUNT: rdata[CNT_W-1:0] = count;
         default:  rdata[0] = ovf;
      endcase
   end
endmodule

// File: rtl/efc_match.sv
module efc_match
   import efc_pkg::*;
#(
   parameter int SLICE_W = 8
) (
   input  match_cfg_t        mcfg,
   input  logic [MA_W-1:0]   req_addr,
   input  logic [FLD_W-1:0]  req_opc,
   input  logic [FLD_W-1:0]  req_cls,
   output logic              hit
);
   localparam int NSL = (MA_W + SLICE_W - 1) / SLICE_W;

   logic [NSL-1:0] slice_eq;
   logic           addr_eq;
   logic           op_eq;

   for (genvar g = 0; g < NSL; g++) begin : g_slice
      localparam int LO = g * SLICE_W;
      localparam int HI = (LO + SLICE_W - 1 > MA_W - 1) ? MA_W - 1 : LO + SLICE_W - 1;
      assign slice_eq[g] = (req_addr[HI:LO] == mcfg.addr[HI:LO]);
   end

   assign addr_eq = &slice_eq;
   assign op_eq   = (req_opc == mcfg.opc) && (req_cls == mcfg.cls);

   always_comb begin
      case (mcfg.sel)
         MS_ADDR: hit = addr_eq;
         MS_OPC:  hit = op_eq;
         MS_BOTH: hit = addr_eq && op_eq;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/efc_counter.sv
module efc_counter #(
   parameter int CNT_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [CNT_W-1:0]  wdata,
   input  logic              inc,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   logic [CNT_W:0] sum;
   assign sum = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (wr) begin
         count <= wdata;
      end else if (inc) begin
         count <= sum[CNT_W-1:0];
         if (sum[CNT_W])
            ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/evt_filter_counter.sv
module evt_filter_counter
   import efc_pkg::*;
#(
   parameter int          PADDR_W    = 40,
   parameter int          CNT_W      = 48,
   parameter int          EVT_W      = 8,
   parameter int          SLICE_W    = 8,
   parameter logic [7:0]  MATCH_CODE = 8'h35
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_addr,
   input  logic [63:0]         cfg_wdata,
   output logic [63:0]         cfg_rdata,
   input  logic                cnt_en,
   input  logic                cnt_clr,
   input  logic                txn_valid,
   input  logic [PADDR_W-1:0]  txn_paddr,
   input  logic [3:0]          txn_opcode,
   input  logic [3:0]          txn_class,
   output logic [CNT_W-1:0]    count_o,
   output logic                ovf_o
);
   if (PADDR_W != ADDR_HI + 1) begin : g_bad_paddr
      $error("PADDR_W must equal the match register address span");
   end
   if (CNT_W < 1 || CNT_W > 64) begin : g_bad_cnt
      $error("CNT_W must lie in 1..64");
   end
   if (EVT_W < 8 || EVT_W > 64) begin : g_bad_evt
      $error("EVT_W must lie in 8..64");
   end
   if (SLICE_W < 1) begin : g_bad_slice
      $error("SLICE_W must be positive");
   end

   logic unused_paddr_lo;
   assign unused_paddr_lo = ^txn_paddr[ADDR_LO-1:0];

   logic [EVT_W-1:0]  evt_sel;
   match_cfg_t        mcfg;
   logic              cnt_wr;

   logic              stg_vld;
   logic [MA_W-1:0]   stg_addr;
   logic [FLD_W-1:0]  stg_opc;
   logic [FLD_W-1:0]  stg_cls;
   logic              flt_hit;
   logic              inc;

   efc_regs #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .count   (count_o),
      .ovf     (ovf_o),
      .evt_sel (evt_sel),
      .mcfg    (mcfg),
      .cnt_wr  (cnt_wr),
      .rdata   (cfg_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_vld  <= 1'b0;
         stg_addr <= '0;
         stg_opc  <= '0;
         stg_cls  <= '0;
      end else begin
         stg_vld  <= txn_valid && cnt_en;
         stg_addr <= txn_paddr[ADDR_HI:ADDR_LO];
         stg_opc  <= txn_opcode;
         stg_cls  <= txn_class;
      end
   end

   efc_match #(.SLICE_W(SLICE_W)) u_match (
      .mcfg     (mcfg),
      .req_addr (stg_addr),
      .req_opc  (stg_opc),
      .req_cls  (stg_cls),
      .hit      (flt_hit)
   );

   assign inc = stg_vld && flt_hit && (evt_sel == EVT_W'(MATCH_CODE));

   efc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .wr    (cnt_wr),
      .wdata (cfg_wdata[CNT_W-1:0]),
      .inc   (inc),
      .count (count_o),
      .ovf   (ovf_o)
   );
endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
   parameter int          CNT_W      = 48,
   parameter int          EVT_W      = 8,
   parameter logic [7:0]  MATCH_CODE = 8'h35
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [1:0]        cfg_addr,
   input logic [63:0]       cfg_rdata,
   input logic              cnt_clr,
   input logic [CNT_W-1:0]  count_o,
   input logic              ovf_o,
   input logic [EVT_W-1:0]  evt_sel,
   input logic [1:0]        msel
);
   logic cwr;
   assign cwr = cfg_we && (cfg_addr == 2'd2);

   // R2: reserved match-register bits read as zero
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == 2'd1) |-> (cfg_rdata[61:48] == '0 && cfg_rdata[2:0] == '0));

   // R3: wrong event code freezes the count
   p_evt_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sel != EVT_W'(MATCH_CODE) && !cnt_clr && !cwr) |=> $stable(count_o));

   // R4: select 00 freezes the count
   p_sel_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (msel == 2'b00 && !cnt_clr && !cwr) |=> $stable(count_o));

   // R8: at most one step per cycle
   p_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clr && !cwr) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

   // R10: clear zeroes count and flag
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (count_o == '0 && !ovf_o));

   // R11: flag is sticky until clear
   p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !cnt_clr) |=> ovf_o);

   // R11: leaving all-ones means wrapping to zero with the flag set
   p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == '1 && !cnt_clr && !cwr) |=> (count_o == '1 || (count_o == '0 && ovf_o)));
endmodule

bind evt_filter_counter efc_checker #(
   .CNT_W(CNT_W), .EVT_W(EVT_W), .MATCH_CODE(MATCH_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_rdata (cfg_rdata),
   .cnt_clr   (cnt_clr),
   .count_o   (count_o),
   .ovf_o     (ovf_o),
   .evt_sel   (evt_sel),
   .msel      (mcfg.sel)
);

// File: tb/evt_filter_counter_tb.sv
`timescale 1ns/100ps
module evt_filter_counter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] cfg_rdata;
   logic        cnt_en = 1'b0;
   logic        cnt_clr = 1'b0;
   logic        txn_valid = 1'b0;
   logic [39:0] txn_paddr = '0;
   logic [3:0]  txn_opcode = '0;
   logic [3:0]  txn_class = '0;
   logic [47:0] count_o;
   logic        ovf_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [47:0] exp_cnt;

   localparam logic [39:0] A0 = 40'h12_3456_7888;

   always #2.5 clk = ~clk;

   evt_filter_counter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cnt_en(cnt_en),
      .cnt_clr(cnt_clr), .txn_valid(txn_valid), .txn_paddr(txn_paddr),
      .txn_opcode(txn_opcode), .txn_class(txn_class),
      .count_o(count_o), .ovf_o(ovf_o)
   );

   function automatic logic [63:0] mk(input logic [1:0] sel, input logic [3:0] cls,
                                      input logic [3:0] op, input logic [39:0] a);
      return {sel, 14'd0, cls, op, a[39:3], 3'b000};
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [63:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic clr();
      @(negedge clk);
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      exp_cnt = '0;
   endtask

   task automatic send(input logic [39:0] a, input logic [3:0] op, input logic [3:0] cl);
      @(negedge clk);
      txn_valid = 1'b1; txn_paddr = a; txn_opcode = op; txn_class = cl;
      @(negedge clk);
      txn_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [63:0] d;
      chk("R1 count", {16'd0, count_o}, 64'd0);
      chk("R1 ovf", {63'd0, ovf_o}, 64'd0);
      rd(2'd0, d); chk("R1 evt", d, 64'd0);
      rd(2'd1, d); chk("R1 match", d, 64'd0);
   endtask

   task automatic t_regs();
      logic [63:0] d;
      wr(2'd1, '1);
      rd(2'd1, d); chk("R2 match mask", d, 64'hC000_FFFF_FFFF_FFF8);
      wr(2'd0, '1);
      rd(2'd0, d); chk("R2 evt mask", d, 64'h0000_0000_0000_00FF);
      wr(2'd3, '1);
      rd(2'd3, d); chk("R2 status ro", d, 64'd0);
   endtask

   task automatic t_addr();
      wr(2'd0, 64'h35);
      wr(2'd1, mk(2'b01, 4'h1, 4'h5, A0));
      clr();
      send(A0 | 40'h7, 4'hA, 4'hE);
      exp_cnt++; chk("R5 low bits ignored", {16'd0, count_o}, {16'd0, exp_cnt});
      send(A0 ^ 40'h8, 4'h5, 4'h1);
      chk("R5 bit3 differs", {16'd0, count_o}, {16'd0, exp_cnt});
      send(A0 ^ 40'h80_0000_0000, 4'h5, 4'h1);
      chk("R5 bit39 differs", {16'd0, count_o}, {16'd0, exp_cnt});
   endtask

   task automatic t_opc();
      wr(2'd1, mk(2'b10, 4'h1, 4'h5, A0));
      clr();
      send(40'h0, 4'h5, 4'h1);
      exp_cnt++; chk("R6 match any addr", {16'd0, count_o}, {16'd0, exp_cnt});
      send(A0, 4'h6, 4'h1);
      chk("R6 opcode differs", {16'd0, count_o}, {16'd0, exp_cnt});
      send(A0, 4'h5, 4'h0);
      chk("R6 class differs", {16'd0, count_o}, {16'd0, exp_cnt});
   endtask

   task automatic t_both();
      wr(2'd1, mk(2'b11, 4'hE, 4'h3, A0));
      clr();
      send(A0, 4'h3, 4'hE);
      exp_cnt++; chk("R7 both match", {16'd0, count_o}, {16'd0, exp_cnt});
      send(A0, 4'h2, 4'hE);
      chk("R7 opcode miss", {16'd0, count_o}, {16'd0, exp_cnt});
      send(A0 ^ 40'h100, 4'h3, 4'hE);
      chk("R7 addr miss", {16'd0, count_o}, {16'd0, exp_cnt});
   endtask

   task automatic t_gates();
      wr(2'd0, 64'h34);
      send(A0, 4'h3, 4'hE);
      chk("R3 wrong event code", {16'd0, count_o}, {16'd0, exp_cnt});
      wr(2'd0, 64'h35);
      cnt_en = 1'b0;
      send(A0, 4'h3, 4'hE);
      chk("R9 enable low", {16'd0, count_o}, {16'd0, exp_cnt});
      cnt_en = 1'b1;
      wr(2'd1, mk(2'b00, 4'hE, 4'h3, A0));
      send(A0, 4'h3, 4'hE);
      chk("R4 select off", {16'd0, count_o}, {16'd0, exp_cnt});
   endtask

   task automatic t_b2b();
      wr(2'd1, mk(2'b11, 4'hE, 4'h3, A0));
      clr();
      @(negedge clk);
      txn_valid = 1'b1; txn_paddr = A0; txn_opcode = 4'h3; txn_class = 4'hE;
      @(negedge clk);
      chk("R8 no change one cycle after", {16'd0, count_o}, 64'd0);
      txn_opcode = 4'h4;
      @(negedge clk);
      chk("R8 first hit after two edges", {16'd0, count_o}, 64'd1);
      txn_opcode = 4'h3;
      @(negedge clk);
      txn_opcode = 4'h3;
      @(negedge clk);
      txn_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R8 back-to-back", {16'd0, count_o}, 64'd3);
      exp_cnt = 48'd3;
   endtask

   task automatic t_clear();
      @(negedge clk);
      txn_valid = 1'b1; txn_paddr = A0; txn_opcode = 4'h3; txn_class = 4'hE;
      @(negedge clk);
      txn_valid = 1'b0; cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      chk("R10 clear beats hit", {16'd0, count_o}, 64'd0);
      exp_cnt = '0;
   endtask

   task automatic t_wrap();
      logic [63:0] d;
      wr(2'd2, 64'h0000_FFFF_FFFF_FFFF);
      rd(2'd2, d); chk("R12 preload readback", d, 64'h0000_FFFF_FFFF_FFFF);
      send(A0, 4'h3, 4'hE);
      chk("R11 wrap count", {16'd0, count_o}, 64'd0);
      rd(2'd3, d); chk("R11 ovf set", d, 64'd1);
      wr(2'd2, 64'd10);
      send(A0, 4'h3, 4'hE);
      chk("R12 count after preload", {16'd0, count_o}, 64'd11);
      chk("R11 ovf sticky", {63'd0, ovf_o}, 64'd1);
      clr();
      chk("R10 ovf cleared", {63'd0, ovf_o}, 64'd0);
      @(negedge clk);
      txn_valid = 1'b1; txn_paddr = A0; txn_opcode = 4'h3; txn_class = 4'hE;
      @(negedge clk);
      txn_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 64'd100;
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R12 write beats hit", {16'd0, count_o}, 64'd100);
   endtask

   initial begin
      exp_cnt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cnt_en = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_addr();
      t_opc();
      t_both();
      t_gates();
      t_b2b();
      t_clear();
      t_wrap();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule